// File: doc/BRIEF.md
# Multicast Hash Destination Address Filter

This block decides whether a received Ethernet frame is meant for this station. Software programs it through a byte-wide register port. The port holds a six-byte station address, a 64-bit multicast hash table and a configuration byte with a receive enable and a promiscuous switch. The two tables are loaded sequentially, one byte per write, and only inside an address-change window. Software opens the window with a request bit and polls that bit until hardware drops it.

During reception the first six bytes of each frame are taken as the destination address. The block runs a reflected CRC-32 over those bytes one byte per cycle and compares them with the station address. After the sixth byte it reports accept or reject. Each part of the filter setup is protected: any request to change an address, and any table byte accepted, turns the receiver off until software writes the configuration register again.

Top module: `mcast_filter`

## Requirements
- R1: After reset, `addr_chg_o`, `rx_en_o`, `promisc_o`, `match_valid_o` and `match_accept_o` are all 0, both tables are zero and no load window is open.
- R2: A write to register select 1 with bit 0 set raises `addr_chg_o` on the next cycle. The bit stays high for exactly CHG_DELAY cycles and then falls, and at that point the load window opens. A write to select 1 with bit 0 clear closes the window and cancels a pending request.
- R3: Writes to the station port (select 2) or the filter port (select 3) made while no load window is open change nothing: the tables, the decisions and `rx_en_o` stay as they were.
- R4: The station address is loaded by writes to select 2. Each write stores one byte, and the first write holds the first destination byte. The station pointer returns to 0 only when a change request carries bit 2. Writes after the sixth are ignored.
- R5: The hash table is loaded by up to eight writes to select 3 in ascending byte order. Byte k holds table bits 8k+7..8k, so hash index bits [5:4] pick a 16-bit word and bits [3:0] pick a bit within it. The logical pointer is reset by a change request carrying bit 1. Writes after the eighth are ignored. An all-ones table accepts every multicast frame and an all-zeros table rejects them all.
- R6: The hash index is bits [31:26] of a CRC-32 register. The register uses the reflected polynomial 0xEDB88320, starts at all ones and is not inverted at the end. It is fed the six destination bytes in order, each byte least significant bit first.
- R7: A multicast frame is one whose first destination byte has bit 0 set and which is not broadcast. When enabled and not promiscuous, such a frame is accepted exactly when its table bit is 1.
- R8: A frame whose first byte has bit 0 clear is accepted, when enabled and not promiscuous, only if all six bytes equal the station address.
- R9: The broadcast address FF:FF:FF:FF:FF:FF is accepted whenever reception is enabled, whatever the table holds.
- R10: With configuration bit 1 (promiscuous) set, every frame is accepted while reception is enabled.
- R11: A write to select 0 loads bit 0 into `rx_en_o` and bit 1 into `promisc_o`. A change request (select 1, bit 0 set) or any accepted table write clears `rx_en_o`. While `rx_en_o` is 0 every frame is rejected.
- R12: A frame starts on a cycle with `rx_valid_i` and `rx_sof_i` both high. `match_valid_o` drops on the cycle after the start and rises on the cycle after the sixth byte. It holds until the next start, and `match_accept_o` is 0 whenever `match_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | 0 config, 1 address-change control, 2 station data, 3 filter data |
| reg_wdata_i | input | 8 | Write data |
| rx_valid_i | input | 1 | Receive byte valid |
| rx_sof_i | input | 1 | First byte of frame (qualified by rx_valid_i) |
| rx_data_i | input | 8 | Receive byte |
| addr_chg_o | output | 1 | Address change request pending |
| rx_en_o | output | 1 | Receive enable |
| promisc_o | output | 1 | Promiscuous mode |
| match_valid_o | output | 1 | Decision valid for current frame |
| match_accept_o | output | 1 | Frame accepted |

## Verification
The bench chases the cases where a single slip turns into a silent wrong answer. A byte-order or bit-order error in the CRC or the table layout would accept the wrong multicast group and reject the programmed one. A station pointer that wraps past six would overwrite the first byte and reject our own unicast frames. A data port that ignores the load window would let stray writes corrupt the table or clear the receive enable. It also checks the broadcast and promiscuous paths against a zero table and a disabled receiver, the exact width of the change-pending window, and that a decision appears one cycle after the sixth byte and holds through trailing bytes.

// File: rtl/mcf_pkg.sv
package mcf_pkg;
  localparam int MAC_BYTES = 6;
  localparam int TBL_BYTES = 8;
  localparam int TBL_BITS  = TBL_BYTES * 8;
  localparam int HASH_W    = $clog2(TBL_BITS);
  localparam int CRC_W     = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'hEDB88320;

  typedef enum logic [1:0] {
    SEL_CFG  = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_STA  = 2'd2,
    SEL_FLT  = 2'd3
  } reg_sel_e;

  localparam int CFG_RXEN = 0;
  localparam int CFG_PROM = 1;
  localparam int CTL_CHG  = 0;
  localparam int CTL_LRST = 1;
  localparam int CTL_PRST = 2;

  // one byte into a reflected CRC, lsb first
  function automatic logic [CRC_W-1:0] crc_byte(input logic [CRC_W-1:0] c, input logic [7:0] d);
    logic [CRC_W-1:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY;
      else             r = r >> 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/mcf_prog.sv
module mcf_prog
  import mcf_pkg::*;
#(
  parameter int CHG_DELAY = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_i,
  input  logic [1:0]             sel_i,
  input  logic [7:0]             wdata_i,
  output logic                   addr_chg_o,
  output logic                   rx_en_o,
  output logic                   promisc_o,
  output logic [MAC_BYTES*8-1:0] sta_o,
  output logic [TBL_BITS-1:0]    tbl_o
);
  localparam int CNT_W  = $clog2(CHG_DELAY + 1);
  localparam int PPTR_W = $clog2(MAC_BYTES + 1);
  localparam int LPTR_W = $clog2(TBL_BYTES + 1);

  logic                   busy_q, load_q, rxen_q, prom_q;
  logic [CNT_W-1:0]       cnt_q;
  logic [PPTR_W-1:0]      pptr_q;
  logic [LPTR_W-1:0]      lptr_q;
  logic [MAC_BYTES*8-1:0] sta_q;
  logic [TBL_BITS-1:0]    tbl_q;

  reg_sel_e sel;
  logic wr_cfg, wr_ctl, sta_ok, flt_ok, chg_req;

  always_comb begin
    sel     = reg_sel_e'(sel_i);
    wr_cfg  = wr_i && (sel == SEL_CFG);
    wr_ctl  = wr_i && (sel == SEL_CTRL);
    chg_req = wr_ctl && wdata_i[CTL_CHG];
    sta_ok  = wr_i && (sel == SEL_STA) && load_q && (pptr_q < PPTR_W'(MAC_BYTES));
    flt_ok  = wr_i && (sel == SEL_FLT) && load_q && (lptr_q < LPTR_W'(TBL_BYTES));
  end

  // change handshake and pointers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      load_q <= 1'b0;
      cnt_q  <= '0;
      pptr_q <= '0;
      lptr_q <= '0;
    end else begin
      if (wr_ctl) begin
        load_q <= 1'b0;
        if (wdata_i[CTL_CHG]) begin
          busy_q <= 1'b1;
          cnt_q  <= CNT_W'(CHG_DELAY);
          if (wdata_i[CTL_LRST]) lptr_q <= '0;
          if (wdata_i[CTL_PRST]) pptr_q <= '0;
        end else begin
          busy_q <= 1'b0;
        end
      end else if (busy_q) begin
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          busy_q <= 1'b0;
          load_q <= 1'b1;
        end
      end
      if (sta_ok) pptr_q <= pptr_q + 1'b1;
      if (flt_ok) lptr_q <= lptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sta_q <= '0;
      tbl_q <= '0;
    end else begin
      for (int b = 0; b < MAC_BYTES; b++)
        if (sta_ok && pptr_q == PPTR_W'(b)) sta_q[b*8 +: 8] <= wdata_i;
      for (int b = 0; b < TBL_BYTES; b++)
        if (flt_ok && lptr_q == LPTR_W'(b)) tbl_q[b*8 +: 8] <= wdata_i;
    end
  end

  // any filter change drops the receiver until config is rewritten
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rxen_q <= 1'b0;
      prom_q <= 1'b0;
    end else if (wr_cfg) begin
      rxen_q <= wdata_i[CFG_RXEN];
      prom_q <= wdata_i[CFG_PROM];
    end else if (chg_req || sta_ok || flt_ok) begin
      rxen_q <= 1'b0;
    end
  end

  assign addr_chg_o = busy_q;
  assign rx_en_o    = rxen_q;
  assign promisc_o  = prom_q;
  assign sta_o      = sta_q;
  assign tbl_o      = tbl_q;
endmodule

// File: rtl/mcf_crc.sv
module mcf_crc
  import mcf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              step_i,
  input  logic [7:0]        data_i,
  output logic [HASH_W-1:0] hash_o
);
  logic [CRC_W-1:0] crc_q, seed, crc_nx;

  always_comb begin
    seed   = start_i ? '1 : crc_q;
    crc_nx = crc_byte(seed, data_i);
    hash_o = crc_nx[CRC_W-1 -: HASH_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= '1;
    else if (step_i) crc_q <= crc_nx;
  end
endmodule

// File: rtl/mcf_match.sv
module mcf_match
  import mcf_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   valid_i,
  input  logic                   sof_i,
  input  logic [7:0]             data_i,
  input  logic [MAC_BYTES*8-1:0] sta_i,
  input  logic [TBL_BITS-1:0]    tbl_i,
  input  logic                   rx_en_i,
  input  logic                   promisc_i,
  input  logic [HASH_W-1:0]      hash_i,
  output logic                   crc_start_o,
  output logic                   crc_step_o,
  output logic                   match_valid_o,
  output logic                   match_accept_o
);
  localparam int IDX_W = $clog2(MAC_BYTES + 1);

  logic [IDX_W-1:0] cnt_q;
  logic eq_q, bc_q, mc_q, valid_q, acc_q;
  logic start, mid, last;
  logic [7:0] sta_b;
  logic eq_nx, bc_nx, mc_nx, acc_nx;

  always_comb begin
    start = valid_i && sof_i;
    mid   = valid_i && !sof_i && (cnt_q < IDX_W'(MAC_BYTES));
    last  = mid && (cnt_q == IDX_W'(MAC_BYTES - 1));
    sta_b = sta_i[7:0];
    for (int b = 1; b < MAC_BYTES; b++)
      if (!start && cnt_q == IDX_W'(b)) sta_b = sta_i[b*8 +: 8];
    eq_nx  = (start || eq_q) && (data_i == sta_b);
    bc_nx  = (start || bc_q) && (data_i == 8'hFF);
    mc_nx  = start ? data_i[0] : mc_q;
    acc_nx = rx_en_i && (bc_nx || promisc_i || (mc_nx ? tbl_i[hash_i] : eq_nx));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= IDX_W'(MAC_BYTES);
      eq_q    <= 1'b0;
      bc_q    <= 1'b0;
      mc_q    <= 1'b0;
      valid_q <= 1'b0;
      acc_q   <= 1'b0;
    end else begin
      if (start || mid) begin
        eq_q <= eq_nx;
        bc_q <= bc_nx;
        mc_q <= mc_nx;
      end
      if (start) begin
        cnt_q   <= IDX_W'(1);
        valid_q <= 1'b0;
        acc_q   <= 1'b0;
      end else if (mid) begin
        cnt_q <= cnt_q + 1'b1;
      end
      if (last) begin
        valid_q <= 1'b1;
        acc_q   <= acc_nx;
      end
    end
  end

  assign crc_start_o    = start;
  assign crc_step_o     = start || mid;
  assign match_valid_o  = valid_q;
  assign match_accept_o = acc_q;
endmodule

// File: rtl/mcast_filter.sv
module mcast_filter
  import mcf_pkg::*;
#(
  parameter int CHG_DELAY = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       reg_wr_i,
  input  logic [1:0] reg_sel_i,
  input  logic [7:0] reg_wdata_i,
  input  logic       rx_valid_i,
  input  logic       rx_sof_i,
  input  logic [7:0] rx_data_i,
  output logic       addr_chg_o,
  output logic       rx_en_o,
  output logic       promisc_o,
  output logic       match_valid_o,
  output logic       match_accept_o
);
  logic [MAC_BYTES*8-1:0] sta;
  logic [TBL_BITS-1:0]    tbl;
  logic [HASH_W-1:0]      hash;
  logic                   crc_start, crc_step;

  mcf_prog #(.CHG_DELAY(CHG_DELAY)) u_prog (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (reg_wr_i),
    .sel_i      (reg_sel_i),
    .wdata_i    (reg_wdata_i),
    .addr_chg_o (addr_chg_o),
    .rx_en_o    (rx_en_o),
    .promisc_o  (promisc_o),
    .sta_o      (sta),
    .tbl_o      (tbl)
  );

  mcf_crc u_crc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (crc_start),
    .step_i  (crc_step),
    .data_i  (rx_data_i),
    .hash_o  (hash)
  );

  mcf_match u_match (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .valid_i        (rx_valid_i),
    .sof_i          (rx_sof_i),
    .data_i         (rx_data_i),
    .sta_i          (sta),
    .tbl_i          (tbl),
    .rx_en_i        (rx_en_o),
    .promisc_i      (promisc_o),
    .hash_i         (hash),
    .crc_start_o    (crc_start),
    .crc_step_o     (crc_step),
    .match_valid_o  (match_valid_o),
    .match_accept_o (match_accept_o)
  );
endmodule

// File: rtl/mcast_filter_chk.sv
module mcast_filter_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       reg_wr_i,
  input logic [1:0] reg_sel_i,
  input logic [7:0] reg_wdata_i,
  input logic       rx_valid_i,
  input logic       rx_sof_i,
  input logic       addr_chg_o,
  input logic       rx_en_o,
  input logic       promisc_o,
  input logic       match_valid_o,
  input logic       match_accept_o
);
  logic chg_wr, cfg_wr, sof;
  assign chg_wr = reg_wr_i && reg_sel_i == 2'd1 && reg_wdata_i[0];
  assign cfg_wr = reg_wr_i && reg_sel_i == 2'd0;
  assign sof    = rx_valid_i && rx_sof_i;

  assert_chg_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_wr |=> addr_chg_o);
  assert_chg_drops_rx_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_wr |=> !rx_en_o);
  assert_cfg_load_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr |=> (rx_en_o == $past(reg_wdata_i[0])) && (promisc_o == $past(reg_wdata_i[1])));
  assert_sof_clear_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof |=> !match_valid_o);
  assert_valid_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_valid_o && !sof) |=> match_valid_o);
  assert_accept_gated_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !match_valid_o |-> !match_accept_o);
endmodule

bind mcast_filter mcast_filter_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .reg_wr_i       (reg_wr_i),
  .reg_sel_i      (reg_sel_i),
  .reg_wdata_i    (reg_wdata_i),
  .rx_valid_i     (rx_valid_i),
  .rx_sof_i       (rx_sof_i),
  .addr_chg_o     (addr_chg_o),
  .rx_en_o        (rx_en_o),
  .promisc_o      (promisc_o),
  .match_valid_o  (match_valid_o),
  .match_accept_o (match_accept_o)
);

// File: tb/tb_mcast_filter.sv
module tb_mcast_filter;
  localparam int DLY = 3;

  logic clk = 1'b0, rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic       wr = 0, rv = 0, rs = 0;
  logic [1:0] sel = 0;
  logic [7:0] wd = 0, rd = 0;
  logic       chg, rxen, prom, mv, ma;

  mcast_filter #(.CHG_DELAY(DLY)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_wr_i(wr), .reg_sel_i(sel), .reg_wdata_i(wd),
    .rx_valid_i(rv), .rx_sof_i(rs), .rx_data_i(rd),
    .addr_chg_o(chg), .rx_en_o(rxen), .promisc_o(prom),
    .match_valid_o(mv), .match_accept_o(ma)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit started = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] bhash(input logic [47:0] a);
    logic [31:0] c = '1;
    for (int i = 0; i < 48; i++) begin
      bit fb = c[0] ^ a[i];
      c = c >> 1;
      if (fb) c = c ^ 32'hEDB88320;
    end
    return c[31:26];
  endfunction

  // behavioural reference model
  bit m_busy, m_load, m_rxen, m_prom, m_valid, m_acc;
  int m_cnt, m_pp, m_lp, m_n;
  logic [7:0] m_sta[6];
  logic [7:0] m_fb[6];
  logic [63:0] m_tbl;
  string m_cls;

  task automatic decide();
    logic [47:0] a;
    bit bc = 1, eq = 1;
    for (int i = 0; i < 6; i++) begin
      a[i*8 +: 8] = m_fb[i];
      if (m_fb[i] != 8'hFF) bc = 0;
      if (m_fb[i] != m_sta[i]) eq = 0;
    end
    m_valid = 1;
    if (!m_rxen)        begin m_acc = 0; m_cls = "R11 disabled"; end
    else if (bc)        begin m_acc = 1; m_cls = "R9 broadcast"; end
    else if (m_prom)    begin m_acc = 1; m_cls = "R10 promisc"; end
    else if (a[0])      begin m_acc = m_tbl[bhash(a)]; m_cls = "R7 multicast"; end
    else                begin m_acc = eq; m_cls = "R8 unicast"; end
  endtask

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_busy = 0; m_load = 0; m_rxen = 0; m_prom = 0; m_valid = 0; m_acc = 0;
      m_cnt = 0; m_pp = 0; m_lp = 0; m_n = 6; m_tbl = '0; m_cls = "R12 idle";
      for (int i = 0; i < 6; i++) m_sta[i] = 8'h00;
    end else begin
      if (rv) begin
        if (rs) begin
          m_fb[0] = rd; m_n = 1; m_valid = 0; m_acc = 0; m_cls = "R12 idle";
        end else if (m_n < 6) begin
          m_fb[m_n] = rd; m_n++;
          if (m_n == 6) decide();
        end
      end
      if (wr) begin
        case (sel)
          2'd0: begin m_rxen = wd[0]; m_prom = wd[1]; end
          2'd1: begin
            m_load = 0;
            if (wd[0]) begin
              m_busy = 1; m_cnt = DLY; m_rxen = 0;
              if (wd[1]) m_lp = 0;
              if (wd[2]) m_pp = 0;
            end else m_busy = 0;
          end
          2'd2: if (m_load && m_pp < 6) begin m_sta[m_pp] = wd; m_pp++; m_rxen = 0; end
          default: if (m_load && m_lp < 8) begin
            m_tbl[m_lp*8 +: 8] = wd; m_lp++; m_rxen = 0;
          end
        endcase
      end
      if (!(wr && sel == 2'd1) && m_busy) begin
        m_cnt--;
        if (m_cnt == 0) begin m_busy = 0; m_load = 1; end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_ni && started) begin
      chk(chg == m_busy, "R2 addr_chg model", chg, m_busy);
      chk(rxen == m_rxen, "R11 rx_en model", rxen, m_rxen);
      chk(prom == m_prom, "R10 promisc model", prom, m_prom);
      chk(mv == m_valid, "R12 valid model", mv, m_valid);
      chk(ma == m_acc, m_cls, ma, m_acc);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      checks++; fails++;
      $display("FAIL watchdog R12 actual=%0d expected=%0d", cyc, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic wreg(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); wr = 1; sel = s; wd = d;
    @(negedge clk); wr = 0;
  endtask

  task automatic open_load(input logic [7:0] bits);
    int n;
    wreg(2'd1, 8'h01 | bits);
    chk(chg == 1, "R2 change pending", chg, 1);
    chk(rxen == 0, "R11 change clears rx_en", rxen, 0);
    n = 1;
    while (chg) begin
      @(negedge clk);
      if (chg) n++;
    end
    chk(n == DLY, "R2 pending width", n, DLY);
  endtask

  task automatic close_load_enable(input logic [7:0] cfg);
    wreg(2'd1, 8'h00);
    wreg(2'd0, cfg);
  endtask

  task automatic send(input logic [47:0] a, input int extra, input bit exp, input string tag);
    for (int i = 0; i < 6 + extra; i++) begin
      @(negedge clk);
      if (i == 1) chk(mv == 0, "R12 valid low mid-frame", mv, 0);
      if (i == 6) chk(mv == 1, "R12 valid one cycle after byte 6", mv, 1);
      rv = 1; rs = (i == 0); rd = (i < 6) ? a[i*8 +: 8] : 8'h5A;
    end
    @(negedge clk); rv = 0; rs = 0;
    chk(mv == 1, "R12 valid held", mv, 1);
    chk(ma == exp, tag, ma, exp);
  endtask

  logic [47:0] st_a, st_bad, st_t, mc_a, mc_b, bcast;
  logic [63:0] tbl_a;

  initial begin
    st_a  = 48'h55_44_33_22_11_02;
    st_bad = 48'h56_44_33_22_11_02;
    st_t  = 48'h0C_0B_0A_09_08_06;
    mc_a  = 48'h01_00_00_5E_00_01;
    mc_b  = 48'h02_00_00_5E_00_01;
    bcast = '1;
    while (bhash(mc_b) == bhash(mc_a)) mc_b[47:40] = mc_b[47:40] + 8'd1;
    tbl_a = 64'd1 << bhash(mc_a);

    repeat (3) @(negedge clk);
    rst_ni = 1;
    started = 1;
    @(negedge clk);
    chk({chg, rxen, prom, mv, ma} == 5'b0, "R1 reset outputs", {chg, rxen, prom, mv, ma}, 0);

    send(bcast, 0, 0, "R11 disabled after reset rejects");
    wreg(2'd0, 8'h01);
    chk(rxen == 1, "R11 config sets rx_en", rxen, 1);
    send(st_a, 0, 0, "R1 station zero rejects unicast");

    open_load(8'h06);
    for (int i = 0; i < 6; i++) wreg(2'd2, st_a[i*8 +: 8]);
    wreg(2'd2, 8'hEE);
    for (int k = 0; k < 8; k++) wreg(2'd3, tbl_a[k*8 +: 8]);
    chk(rxen == 0, "R11 table write keeps rx off", rxen, 0);
    close_load_enable(8'h01);

    send(st_a, 0, 1, "R4 R8 exact station accepted");
    send(st_bad, 0, 0, "R8 mismatched unicast rejected");
    send(bcast, 2, 1, "R9 broadcast accepted");
    send(mc_a, 1, 1, "R5 R6 R7 hashed group accepted");
    send(mc_b, 0, 0, "R7 unhashed group rejected");

    wreg(2'd3, 8'hFF);
    wreg(2'd2, 8'h00);
    chk(rxen == 1, "R3 stray write leaves rx_en", rxen, 1);
    send(mc_b, 0, 0, "R3 stray filter write ignored");
    send(st_a, 0, 1, "R3 stray station write ignored");

    wreg(2'd0, 8'h03);
    send(st_bad, 0, 1, "R10 promisc accepts unicast");
    send(mc_b, 0, 1, "R10 promisc accepts multicast");
    wreg(2'd0, 8'h00);
    send(bcast, 0, 0, "R11 disabled rejects broadcast");

    open_load(8'h02);
    for (int k = 0; k < 8; k++) wreg(2'd3, 8'hFF);
    wreg(2'd3, 8'h00);
    close_load_enable(8'h01);
    send(mc_b, 0, 1, "R5 all-ones table accepts");
    send(st_a, 0, 1, "R4 station kept without pointer reset");

    open_load(8'h02);
    for (int k = 0; k < 8; k++) wreg(2'd3, 8'h00);
    close_load_enable(8'h01);
    send(mc_a, 0, 0, "R5 all-zeros table rejects");
    send(bcast, 0, 1, "R9 broadcast with zero table");

    open_load(8'h04);
    for (int i = 0; i < 6; i++) wreg(2'd2, st_t[i*8 +: 8]);
    close_load_enable(8'h01);
    send(st_t, 0, 1, "R4 reloaded station accepted");
    send(st_a, 0, 0, "R4 old station rejected");

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule